// File: doc/BRIEF.md
# Condition-Register Field Lookup-Table Unit

This block executes bitwise lookup-table operations on a 32-bit condition register that it holds internally and that is split into eight 4-bit fields. Each operation names a destination field and two operand fields by number. It computes a 4-bit result, one bit position at a time, by indexing a small truth table. A 4-bit write mask then merges that result into the destination field.

Two operation kinds are supported. In the two-input kind, the truth table is the current contents of one operand field. The index for each bit comes from the other operand field and from the destination field itself. In the three-input kind, the truth table is an 8-bit immediate, and the index combines the same bit position of all three named fields.

The surrounding pipeline presents one decoded operation per cycle with a valid strobe. One clock later, the updated register appears on the output together with a one-cycle done pulse. Operations presented on consecutive cycles chain: each one sees the result of the one before.

Top module: `crf_lut_unit`

## Requirements
- R1: A synchronous reset clears the whole condition register to zero and holds `op_done` low.
- R2: Field number n occupies register bits [31-4n : 28-4n]. Field 0 is therefore the top nibble and field 7 the bottom nibble. Within a field, bit i is the field value's bit i, with bit 0 being the least significant.
- R3: Two-input kind (`op_kind`=0): result bit i is bit k of the table field (`fld_tbl`), where k = 2*dst[i] + src[i]. Here dst is the destination field and src is the field named by `fld_src`.
- R4: Three-input kind (`op_kind`=1): result bit i is `op_imm` bit k, where k = 4*dst[i] + 2*src[i] + tbl[i].
- R5: Destination bit i takes the result bit where `op_mask` bit i is 1. Where the mask bit is 0, the destination bit keeps its old value.
- R6: An operation changes no field other than the destination. Operand fields that differ from the destination stay as they were.
- R7: A mask of zero leaves the whole register unchanged, whatever the table or immediate holds.
- R8: The updated register and a single-cycle `op_done` pulse appear exactly one clock after `op_valid` is sampled high. Without `op_valid`, the register holds and `op_done` stays low.
- R9: When the destination number equals an operand number, the operand value used is the one held before the write.
- R10: Operations on consecutive cycles chain. Each one reads the register as updated by the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 1 | 0 = two-input field-table form, 1 = three-input immediate form |
| fld_dst | input | 3 | Destination field number (also an index source) |
| fld_src | input | 3 | First operand field number |
| fld_tbl | input | 3 | Second operand field number (the table in the two-input form) |
| op_mask | input | 4 | Per-bit write mask |
| op_imm | input | 8 | Truth table for the three-input form |
| cr_out | output | 32 | Current condition register |
| op_done | output | 1 | Pulses one cycle after an accepted operation |

## Verification
Every result of this block is due on the clock edge right after `op_valid` is sampled: both the register and the done pulse move on that edge and on no other. The bench drives operations on the falling edge. Its reference model advances on the same rising edge as the design, and the outputs are compared on the next falling edge, so each comparison sees exactly one edge's worth of change. Directed checks wait one edge after the final operation they depend on. For chained operations, no check is made until the last one in the chain has taken effect.

// File: rtl/crf_lut_pkg.sv
package crf_lut_pkg;

    typedef enum logic {
        LUT_TWO   = 1'b0,
        LUT_THREE = 1'b1
    } lut_kind_e;

    localparam int TWO_TBL_W   = 4;
    localparam int THREE_TBL_W = 8;

endpackage

// File: rtl/crf_field_sel.sv
module crf_field_sel #(
    parameter int NF = 8,
    parameter int FW = 4,
    localparam int CR_W  = NF * FW,
    localparam int IDX_W = $clog2(NF)
) (
    input  logic [CR_W-1:0]  cr,
    input  logic [IDX_W-1:0] sel,
    output logic [FW-1:0]    fld
);

    logic [FW-1:0] slots [NF];

    // field 0 sits at the top of the register
    for (genvar g = 0; g < NF; g++) begin : g_slot
        assign slots[g] = cr[CR_W-1-g*FW -: FW];
    end

    always_comb begin
        fld = slots[sel];
    end

endmodule

// File: rtl/crf_lut_core.sv
module crf_lut_core
    import crf_lut_pkg::*;
#(
    parameter int FW = 4
) (
    input  lut_kind_e              kind,
    input  logic [FW-1:0]          dst,
    input  logic [FW-1:0]          src,
    input  logic [FW-1:0]          tbl,
    input  logic [THREE_TBL_W-1:0] imm,
    output logic [FW-1:0]          res
);

    logic [TWO_TBL_W-1:0] two_tbl;
    assign two_tbl = tbl[TWO_TBL_W-1:0];

    for (genvar g = 0; g < FW; g++) begin : g_bit
        logic [1:0] idx_two;
        logic [2:0] idx_three;
        logic       out_two;
        logic       out_three;

        assign idx_two   = {dst[g], src[g]};
        assign idx_three = {dst[g], src[g], tbl[g]};
        assign out_two   = two_tbl[idx_two];
        assign out_three = imm[idx_three];
        assign res[g]    = (kind == LUT_THREE) ? out_three : out_two;
    end

endmodule

// File: rtl/crf_field_merge.sv
module crf_field_merge #(
    parameter int NF = 8,
    parameter int FW = 4,
    localparam int CR_W  = NF * FW,
    localparam int IDX_W = $clog2(NF)
) (
    input  logic [CR_W-1:0]  cr_old,
    input  logic [IDX_W-1:0] dst_sel,
    input  logic [FW-1:0]    res,
    input  logic [FW-1:0]    mask,
    output logic [CR_W-1:0]  cr_new
);

    for (genvar g = 0; g < NF; g++) begin : g_field
        logic          hit;
        logic [FW-1:0] old_f;
        logic [FW-1:0] mix_f;

        assign hit   = (dst_sel == IDX_W'(g));
        assign old_f = cr_old[CR_W-1-g*FW -: FW];
        assign mix_f = (old_f & ~mask) | (res & mask);
        assign cr_new[CR_W-1-g*FW -: FW] = hit ? mix_f : old_f;
    end

endmodule

// File: rtl/crf_lut_unit.sv
module crf_lut_unit
    import crf_lut_pkg::*;
#(
    parameter int NF = 8,
    parameter int FW = 4,
    localparam int CR_W  = NF * FW,
    localparam int IDX_W = $clog2(NF)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   op_valid,
    input  logic                   op_kind,
    input  logic [IDX_W-1:0]       fld_dst,
    input  logic [IDX_W-1:0]       fld_src,
    input  logic [IDX_W-1:0]       fld_tbl,
    input  logic [FW-1:0]          op_mask,
    input  logic [THREE_TBL_W-1:0] op_imm,
    output logic [CR_W-1:0]        cr_out,
    output logic                   op_done
);

    typedef struct packed {
        logic [CR_W-1:0] cr;
        logic            done;
    } state_t;

    state_t st_d, st_q;

    logic [FW-1:0]   dst_f, src_f, tbl_f, res_f;
    logic [CR_W-1:0] cr_merged;
    lut_kind_e       kind;

    assign kind = lut_kind_e'(op_kind);

    // all operands come from the registered value, so aliasing sees pre-write data
    crf_field_sel #(.NF(NF), .FW(FW)) u_sel_dst (
        .cr(st_q.cr), .sel(fld_dst), .fld(dst_f)
    );
    crf_field_sel #(.NF(NF), .FW(FW)) u_sel_src (
        .cr(st_q.cr), .sel(fld_src), .fld(src_f)
    );
    crf_field_sel #(.NF(NF), .FW(FW)) u_sel_tbl (
        .cr(st_q.cr), .sel(fld_tbl), .fld(tbl_f)
    );

    crf_lut_core #(.FW(FW)) u_core (
        .kind(kind), .dst(dst_f), .src(src_f), .tbl(tbl_f),
        .imm(op_imm), .res(res_f)
    );

    crf_field_merge #(.NF(NF), .FW(FW)) u_merge (
        .cr_old(st_q.cr), .dst_sel(fld_dst), .res(res_f),
        .mask(op_mask), .cr_new(cr_merged)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = op_valid;
        if (op_valid) begin
            st_d.cr = cr_merged;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cr_out  = st_q.cr;
    assign op_done = st_q.done;

endmodule

// File: rtl/crf_lut_unit_chk.sv
module crf_lut_unit_chk #(
    parameter int NF = 8,
    parameter int FW = 4,
    localparam int CR_W  = NF * FW,
    localparam int IDX_W = $clog2(NF)
) (
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic [IDX_W-1:0] fld_dst,
    input logic [FW-1:0]    op_mask,
    input logic [CR_W-1:0]  cr_out,
    input logic             op_done
);

    logic             vld_prev;
    logic             rst_prev;
    logic [IDX_W-1:0] dst_prev;
    logic [FW-1:0]    msk_prev;
    logic [CR_W-1:0]  msk_wide;

    always_ff @(posedge clk) begin
        rst_prev <= rst;
        vld_prev <= rst ? 1'b0 : op_valid;
        dst_prev <= fld_dst;
        msk_prev <= op_mask;
    end

    always_comb begin
        msk_wide = ({{(CR_W-FW){1'b0}}, msk_prev} << (CR_W - FW)) >> (FW * int'(dst_prev));
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        rst_prev |-> (cr_out == '0 && !op_done));

    p_done_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        vld_prev |-> op_done);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!vld_prev && !rst_prev) |-> (!op_done && $stable(cr_out)));

    p_write_confined_r5_r6: assert property (@(posedge clk) disable iff (rst)
        (vld_prev && !rst_prev) |-> (((cr_out ^ $past(cr_out)) & ~msk_wide) == '0));

    p_zero_mask_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (vld_prev && !rst_prev && msk_prev == '0) |-> $stable(cr_out));

endmodule

bind crf_lut_unit crf_lut_unit_chk #(.NF(NF), .FW(FW)) u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .fld_dst(fld_dst),
    .op_mask(op_mask), .cr_out(cr_out), .op_done(op_done)
);

// File: tb/crf_lut_unit_bench.sv
`timescale 1ns/1ps
module crf_lut_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic        op_kind = 1'b0;
    logic [2:0]  fld_dst = '0, fld_src = '0, fld_tbl = '0;
    logic [3:0]  op_mask = '0;
    logic [7:0]  op_imm = '0;
    logic [31:0] cr_out;
    logic        op_done;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit started = 0;

    logic [31:0] exp_cr = '0;
    logic        exp_done = 1'b0;
    string       req_pend = "R1";
    string       req_now  = "R1";

    always #2 clk = ~clk;

    crf_lut_unit u_crf_lut_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .fld_dst(fld_dst), .fld_src(fld_src), .fld_tbl(fld_tbl),
        .op_mask(op_mask), .op_imm(op_imm), .cr_out(cr_out), .op_done(op_done)
    );

    function automatic logic [3:0] get_f(logic [31:0] cr, int n);
        return 4'((cr >> (4 * (7 - n))) & 32'hF);
    endfunction

    function automatic logic [31:0] ref_step(logic [31:0] cr, logic kind, int d, int s, int t,
                                             logic [3:0] m, logic [7:0] imm);
        logic [3:0] vd, vs, vt, nv;
        int k;
        logic bitv;
        vd = get_f(cr, d); vs = get_f(cr, s); vt = get_f(cr, t);
        for (int i = 0; i < 4; i++) begin
            if (kind == 1'b0) begin
                k = 2 * int'(vd[i]) + int'(vs[i]);
                bitv = vt[k];
            end else begin
                k = 4 * int'(vd[i]) + 2 * int'(vs[i]) + int'(vt[i]);
                bitv = imm[k];
            end
            nv[i] = m[i] ? bitv : vd[i];
        end
        cr = cr & ~(32'hF << (4 * (7 - d)));
        return cr | (32'(nv) << (4 * (7 - d)));
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        req_now <= req_pend;
        if (rst) begin
            exp_cr   <= '0;
            exp_done <= 1'b0;
        end else begin
            exp_done <= op_valid;
            if (op_valid)
                exp_cr <= ref_step(exp_cr, op_kind, int'(fld_dst), int'(fld_src),
                                   int'(fld_tbl), op_mask, op_imm);
        end
    end

    always @(negedge clk) begin
        if (started) begin
            tests++;
            if (cr_out !== exp_cr || op_done !== exp_done) begin
                fails++;
                $display("FAIL %s model compare: cr=%h done=%b expected cr=%h done=%b",
                         req_now, cr_out, op_done, exp_cr, exp_done);
            end
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
            finish_run();
        end
    end

    task automatic chk_cr(logic [31:0] expv, string req);
        tests++;
        if (cr_out !== expv) begin
            fails++;
            $display("FAIL %s: cr=%h expected %h", req, cr_out, expv);
        end
    endtask

    task automatic chk_f(int n, logic [3:0] expv, string req);
        tests++;
        if (get_f(cr_out, n) !== expv) begin
            fails++;
            $display("FAIL %s: field%0d=%b expected %b", req, n, get_f(cr_out, n), expv);
        end
    endtask

    task automatic drive(logic kind, int d, int s, int t, logic [3:0] m, logic [7:0] imm,
                         string req);
        op_valid = 1'b1; op_kind = kind;
        fld_dst = 3'(d); fld_src = 3'(s); fld_tbl = 3'(t);
        op_mask = m; op_imm = imm; req_pend = req;
    endtask

    // one operation; returns on the falling edge where its result is visible
    task automatic issue(logic kind, int d, int s, int t, logic [3:0] m, logic [7:0] imm,
                         string req);
        @(negedge clk);
        drive(kind, d, s, t, m, imm, req);
        @(negedge clk);
        op_valid = 1'b0;
        tests++;
        if (op_done !== 1'b1) begin
            fails++;
            $display("FAIL R8: done=%b expected 1", op_done);
        end
    endtask

    task automatic set_f(int n, logic [3:0] v);
        issue(1'b1, n, n, n, v, 8'hFF, "R5");
        issue(1'b1, n, n, n, ~v, 8'h00, "R5");
    endtask

    initial begin
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        chk_cr(32'h0, "R1");
        tests++;
        if (op_done !== 1'b0) begin
            fails++;
            $display("FAIL R1: done=%b expected 0", op_done);
        end
        rst = 1'b0;

        // R2 layout
        set_f(0, 4'hF);
        chk_cr(32'hF000_0000, "R2");
        set_f(7, 4'h3);
        chk_cr(32'hF000_0003, "R2");
        set_f(0, 4'h0); set_f(7, 4'h0);

        // R3 two-input form, R6 operands untouched
        set_f(3, 4'b1111); set_f(4, 4'b1100); set_f(5, 4'b1000);
        issue(1'b0, 3, 4, 5, 4'b1111, 8'h00, "R3");
        chk_f(3, 4'b1100, "R3");
        chk_f(4, 4'b1100, "R6");
        chk_f(5, 4'b1000, "R6");

        // R4 three-input index order
        set_f(3, 4'b1010); set_f(4, 4'b1100); set_f(5, 4'b0110);
        issue(1'b1, 3, 4, 5, 4'b1111, 8'hF0, "R4");
        chk_f(3, 4'b1010, "R4");
        issue(1'b1, 3, 4, 5, 4'b1111, 8'hCC, "R4");
        chk_f(3, 4'b1100, "R4");
        set_f(3, 4'b1010);
        issue(1'b1, 3, 4, 5, 4'b1111, 8'hAA, "R4");
        chk_f(3, 4'b0110, "R4");

        // R5 partial mask
        set_f(3, 4'b1010);
        issue(1'b1, 3, 4, 5, 4'b0101, 8'hCC, "R5");
        chk_f(3, 4'b1110, "R5");

        // R7 zero mask
        snap = cr_out;
        issue(1'b1, 3, 4, 5, 4'b0000, 8'hFF, "R7");
        chk_cr(snap, "R7");
        issue(1'b0, 4, 3, 5, 4'b0000, 8'h00, "R7");
        chk_cr(snap, "R7");

        // R8 idle cycle: no done, register holds
        @(negedge clk);
        tests++;
        if (op_done !== 1'b0 || cr_out !== snap) begin
            fails++;
            $display("FAIL R8: idle done=%b cr=%h expected 0 %h", op_done, cr_out, snap);
        end

        // R9 all three names equal
        set_f(2, 4'b0110);
        issue(1'b0, 2, 2, 2, 4'b1111, 8'h00, "R9");
        chk_f(2, 4'b0000, "R9");

        // R10 back-to-back chaining
        set_f(1, 4'b0000);
        @(negedge clk);
        drive(1'b1, 1, 1, 1, 4'b0011, 8'hFF, "R10");
        @(negedge clk);
        drive(1'b0, 1, 1, 1, 4'b1111, 8'h00, "R10");
        @(negedge clk);
        op_valid = 1'b0;
        chk_f(1, 4'b1100, "R10");

        // random mix against the model
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            if ($urandom_range(0, 3) == 0) begin
                op_valid = 1'b0;
                req_pend = "R8";
            end else begin
                drive(1'($urandom_range(0, 1)), $urandom_range(0, 7), $urandom_range(0, 7),
                      $urandom_range(0, 7), 4'($urandom_range(0, 15)),
                      8'($urandom_range(0, 255)), "R3/R4 random");
            end
        end
        @(negedge clk);
        op_valid = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule